// File: doc/BRIEF.md
# Flash Window Chip-Select Decoder

This block sits behind a memory-mapped flash window and decides which of up to four flash devices a bus read targets. The devices sit on two channels, A and B, each with a first and a second device, and each device owns one address region. A region runs from the top of the region before it (or from the window base, for the first device of channel A) up to its own top address. A request address is compared against all four regions at once. The block returns a one-hot chip select, the offset of the address inside the chosen device, and a flag for addresses that fall in no region.

The four top addresses can be loaded one at a time through a small write port, or all together by a layout command. The layout command takes the window base, the window size and a chip-select count of two or four. With four chip selects the window splits into four equal consecutive regions. With two, only the first device of each channel gets space, and the second devices have zero size. Any other count is a configuration error and leaves the decoder disabled until a valid layout arrives.

Read data from the flash is passed to the bus for an in-range response and forced to zero otherwise.

Top module: `flash_cs_decoder`

## Requirements
- R1: After reset every output is zero and the decoder is disabled, so the first request after reset gets a response with `outOfRange` = 1 and `csSel` = 0.
- R2: A request presented with `reqValid` on a clock edge is answered on the next edge with `rspValid` = 1. In a cycle after an edge with no request, `rspValid`, `csSel`, `outOfRange` and `offset` are all zero.
- R3: Region n spans from its start address (inclusive) to its top address (exclusive). The start of the first region is `windowBase`, and the start of every other region is the top of the region before it. `csSel` bit 0, 1, 2 and 3 select channel A device 1, channel A device 2, channel B device 1 and channel B device 2.
- R4: A layout command with `csCount` = 4 sets the per-device size to `windowSize` >> 2 and the tops to base + 1, 2, 3 and 4 times that size, giving four equal consecutive regions.
- R5: A layout command with `csCount` = 2 sets the per-device size to `windowSize` >> 1. Both channel A tops become base + size and both channel B tops become base + 2 × size, so `csSel` bits 1 and 3 are never raised.
- R6: A layout command with any `csCount` other than 2 or 4 disables the decoder. Every later response has `outOfRange` = 1 until a layout command with a valid count re-enables it.
- R7: An address below `windowBase`, or at or above the last region's top, gives `csSel` = 0 and `outOfRange` = 1.
- R8: For an in-range response, `offset` equals the request address minus the start of the selected region.
- R9: `rdData` equals `flashData` during an in-range response and is zero otherwise.
- R10: The write port loads `topWrData` into the top register chosen by `topWrIdx` (0 = A1, 1 = A2, 2 = B1, 3 = B2). The new top applies to requests from the next edge on. A write does not enable a disabled decoder.
- R11: A region whose top equals the top of the region before it is never selected, and its addresses fall to the next non-empty region.
- R12: `csSel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| windowBase | input | ADDR_W | Start address of the flash window |
| windowSize | input | ADDR_W | Total window size used by a layout command |
| csCount | input | 3 | Chip-select count used by a layout command (2 or 4 valid) |
| layoutGo | input | 1 | Load all four tops from base, size and count |
| topWrEn | input | 1 | Write one top register |
| topWrIdx | input | 2 | Top register to write (0 = A1, 1 = A2, 2 = B1, 3 = B2) |
| topWrData | input | ADDR_W | Value for the written top register |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request address |
| flashData | input | DATA_W | Read data from the flash side |
| rspValid | output | 1 | Response for the request of the previous cycle |
| csSel | output | 4 | One-hot chip select |
| offset | output | ADDR_W | Address offset inside the selected device |
| outOfRange | output | 1 | Request hit no region or decoder disabled |
| rdData | output | DATA_W | Read data, zero unless the response is in range |

## Verification
The assertions assume that `windowBase` plus `windowSize` does not wrap past the top of the 32-bit space. They also assume that tops loaded through the write port keep ascending order wherever a test relies on region order. The offset check for the first region takes `windowBase` as sampled in the request cycle, so it does not depend on the base staying fixed. The directed stimulus picks a base and size well below 4 GB, changes `windowBase` only between scenarios, and writes only tops that equal or exceed the previous one. This keeps every region either empty or ascending.

// File: rtl/flash_cs_pkg.sv
package flash_cs_pkg;

  // number of device regions: two channels, two devices each
  localparam int NUM_DEV   = 4;
  localparam int IDX_W     = $clog2(NUM_DEV);
  localparam int CNT_W     = 3;
  localparam int CS_PAIR   = 2;
  localparam int CS_QUAD   = 4;

  typedef enum logic [IDX_W-1:0] {
    DEV_A1 = 2'd0,
    DEV_A2 = 2'd1,
    DEV_B1 = 2'd2,
    DEV_B2 = 2'd3
  } devIdx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_DEV-1:0] topLoad;
    logic               layoutLoad;
    logic               layoutFour;
    logic               capture;
    logic               enabled;
  } dpCtrl_t;

endpackage

// File: rtl/flash_cs_ctrl.sv
module flash_cs_ctrl
  import flash_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] csCount,
  input  logic             layoutGo,
  input  logic             topWrEn,
  input  logic [IDX_W-1:0] topWrIdx,
  input  logic             reqValid,
  output dpCtrl_t          strb
);

  logic countOk;
  logic countQuad;
  logic enabledQ;

  assign countQuad = (csCount == CNT_W'(CS_QUAD));
  assign countOk   = countQuad || (csCount == CNT_W'(CS_PAIR));

  // the layout command alone decides whether the decoder runs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabledQ <= 1'b0;
    end else if (layoutGo) begin
      enabledQ <= countOk;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gTopLoad
    assign strb.topLoad[g] = topWrEn && (topWrIdx == IDX_W'(g));
  end

  assign strb.layoutLoad = layoutGo && countOk;
  assign strb.layoutFour = countQuad;
  assign strb.capture    = reqValid;
  assign strb.enabled    = enabledQ;

endmodule

// File: rtl/flash_cs_datapath.sv
module flash_cs_datapath
  import flash_cs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            strb,
  input  logic [ADDR_W-1:0]  windowBase,
  input  logic [ADDR_W-1:0]  windowSize,
  input  logic [ADDR_W-1:0]  topWrData,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  flashData,
  output logic               rspValid,
  output logic [NUM_DEV-1:0] csSel,
  output logic [ADDR_W-1:0]  offset,
  output logic               outOfRange,
  output logic [DATA_W-1:0]  rdData
);

  logic [ADDR_W-1:0]  topQ      [NUM_DEV];
  logic [ADDR_W-1:0]  layoutTop [NUM_DEV];
  logic [ADDR_W-1:0]  regStart  [NUM_DEV];
  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] selOh;
  logic [ADDR_W-1:0]  selStart;
  logic               found;
  logic [ADDR_W-1:0]  perQuad;
  logic [ADDR_W-1:0]  perPair;

  assign perQuad = windowSize >> 2;
  assign perPair = windowSize >> 1;

  for (genvar g = 0; g < NUM_DEV; g++) begin : gRegion
    localparam int QUAD_MUL = g + 1;
    localparam int PAIR_MUL = g / 2 + 1;

    // layout values: equal steps for four devices, channel pairs for two
    assign layoutTop[g] = windowBase +
      (strb.layoutFour ? perQuad * ADDR_W'(QUAD_MUL)
                       : perPair * ADDR_W'(PAIR_MUL));

    if (g == 0) begin : gFirst
      assign regStart[g] = windowBase;
    end else begin : gChain
      assign regStart[g] = topQ[g-1];
    end

    assign hit[g] = (reqAddr >= regStart[g]) && (reqAddr < topQ[g]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        topQ[g] <= '0;
      end else if (strb.layoutLoad) begin
        topQ[g] <= layoutTop[g];
      end else if (strb.topLoad[g]) begin
        topQ[g] <= topWrData;
      end
    end
  end

  // lowest region wins, keeping the select one-hot
  always_comb begin
    selOh    = '0;
    selStart = windowBase;
    found    = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (!found && hit[i]) begin
        selOh[i] = 1'b1;
        selStart = regStart[i];
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      csSel      <= '0;
      offset     <= '0;
      outOfRange <= 1'b0;
    end else begin
      rspValid   <= strb.capture;
      csSel      <= (strb.capture && strb.enabled) ? selOh : '0;
      outOfRange <= strb.capture && !(strb.enabled && found);
      offset     <= (strb.capture && strb.enabled && found) ?
                    reqAddr - selStart : '0;
    end
  end

  assign rdData = (rspValid && !outOfRange) ? flashData : '0;

endmodule

// File: rtl/flash_cs_decoder.sv
module flash_cs_decoder
  import flash_cs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  windowBase,
  input  logic [ADDR_W-1:0]  windowSize,
  input  logic [CNT_W-1:0]   csCount,
  input  logic               layoutGo,
  input  logic               topWrEn,
  input  logic [IDX_W-1:0]   topWrIdx,
  input  logic [ADDR_W-1:0]  topWrData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  flashData,
  output logic               rspValid,
  output logic [NUM_DEV-1:0] csSel,
  output logic [ADDR_W-1:0]  offset,
  output logic               outOfRange,
  output logic [DATA_W-1:0]  rdData
);

  dpCtrl_t strb;

  flash_cs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csCount  (csCount),
    .layoutGo (layoutGo),
    .topWrEn  (topWrEn),
    .topWrIdx (topWrIdx),
    .reqValid (reqValid),
    .strb     (strb)
  );

  flash_cs_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .windowBase (windowBase),
    .windowSize (windowSize),
    .topWrData  (topWrData),
    .reqAddr    (reqAddr),
    .flashData  (flashData),
    .rspValid   (rspValid),
    .csSel      (csSel),
    .offset     (offset),
    .outOfRange (outOfRange),
    .rdData     (rdData)
  );

endmodule

// File: rtl/flash_cs_checker.sv
module flash_cs_checker
  import flash_cs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  windowBase,
  input logic [CNT_W-1:0]   csCount,
  input logic               layoutGo,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               rspValid,
  input logic [NUM_DEV-1:0] csSel,
  input logic [ADDR_W-1:0]  offset,
  input logic               outOfRange,
  input logic [DATA_W-1:0]  rdData
);

  // shadow of the disabled condition, seen from the ports
  logic notRunning;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      notRunning <= 1'b1;
    end else if (layoutGo) begin
      notRunning <= !((csCount == CNT_W'(CS_PAIR)) || (csCount == CNT_W'(CS_QUAD)));
    end
  end

  // R12
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSel));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && csSel == '0 && !outOfRange && offset == '0));

  // R7
  miss_xor_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((csSel != '0) != outOfRange));

  // R9
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (rdData == '0));

  // R6
  disabled_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && notRunning) |=> outOfRange);

  // R8
  first_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && csSel[0]) |-> (offset == $past(reqAddr) - $past(windowBase)));

endmodule

bind flash_cs_decoder flash_cs_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .windowBase (windowBase),
  .csCount    (csCount),
  .layoutGo   (layoutGo),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .rspValid   (rspValid),
  .csSel      (csSel),
  .offset     (offset),
  .outOfRange (outOfRange),
  .rdData     (rdData)
);

// File: tb/tb_flash_cs_decoder.sv
`timescale 1ns/1ps
module tb_flash_cs_decoder;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] BASE = 32'h6000_0000;
  localparam logic [AW-1:0] SIZE = 32'h0400_0000;
  localparam logic [AW-1:0] QTR  = 32'h0100_0000;
  localparam logic [AW-1:0] HALF = 32'h0200_0000;
  localparam logic [DW-1:0] FDATA = 32'hCAFE_0001;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] windowBase = BASE;
  logic [AW-1:0] windowSize = SIZE;
  logic [2:0]    csCount = 3'd0;
  logic          layoutGo = 1'b0;
  logic          topWrEn = 1'b0;
  logic [1:0]    topWrIdx = 2'd0;
  logic [AW-1:0] topWrData = '0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] flashData = FDATA;
  logic          rspValid;
  logic [3:0]    csSel;
  logic [AW-1:0] offset;
  logic          outOfRange;
  logic [DW-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_cs_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .windowBase(windowBase), .windowSize(windowSize),
    .csCount(csCount), .layoutGo(layoutGo), .topWrEn(topWrEn),
    .topWrIdx(topWrIdx), .topWrData(topWrData), .reqValid(reqValid),
    .reqAddr(reqAddr), .flashData(flashData), .rspValid(rspValid),
    .csSel(csSel), .offset(offset), .outOfRange(outOfRange), .rdData(rdData)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic layout(logic [2:0] cnt);
    @(negedge clk);
    csCount  = cnt;
    layoutGo = 1'b1;
    @(negedge clk);
    layoutGo = 1'b0;
  endtask

  task automatic writeTop(logic [1:0] idx, logic [AW-1:0] val);
    @(negedge clk);
    topWrEn   = 1'b1;
    topWrIdx  = idx;
    topWrData = val;
    @(negedge clk);
    topWrEn   = 1'b0;
  endtask

  // one request; response registered at the next edge, sampled 1 ns later
  task automatic request(string req, logic [AW-1:0] addr, logic [3:0] expCs,
                         logic expMiss, logic [AW-1:0] expOff);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = addr;
    @(posedge clk);
    #1;
    check(req, "rspValid", 64'(rspValid), 64'd1);
    check(req, "csSel", 64'(csSel), 64'(expCs));
    check(req, "outOfRange", 64'(outOfRange), 64'(expMiss));
    check(req, "offset", 64'(offset), 64'(expOff));
    check("R9", "rdData", 64'(rdData), expMiss ? 64'd0 : 64'(FDATA));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rspValid", 64'(rspValid), 64'd0);
    check("R1", "csSel", 64'(csSel), 64'd0);
    check("R1", "offset", 64'(offset), 64'd0);
    check("R1", "outOfRange", 64'(outOfRange), 64'd0);
    check("R1", "rdData", 64'(rdData), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    request("R1", BASE, 4'b0000, 1'b1, '0);
  endtask

  task automatic testWriteNoEnable();
    // R10: a direct write while disabled leaves the decoder off
    writeTop(2'd0, BASE + 32'h1000_0000);
    request("R10", BASE + 32'h10, 4'b0000, 1'b1, '0);
  endtask

  task automatic testQuad();
    layout(3'd4);
    request("R4", BASE, 4'b0001, 1'b0, '0);
    request("R3", BASE + QTR - 1, 4'b0001, 1'b0, QTR - 1);
    request("R3", BASE + QTR, 4'b0010, 1'b0, '0);
    request("R4", BASE + 2*QTR + 32'h44, 4'b0100, 1'b0, 32'h44);
    request("R8", BASE + 3*QTR + 5, 4'b1000, 1'b0, 32'd5);
    request("R7", BASE + 4*QTR, 4'b0000, 1'b1, '0);
    request("R7", BASE - 1, 4'b0000, 1'b1, '0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    check("R2", "idle rspValid", 64'(rspValid), 64'd0);
    check("R2", "idle csSel", 64'(csSel), 64'd0);
    check("R2", "idle outOfRange", 64'(outOfRange), 64'd0);
  endtask

  task automatic testPair();
    layout(3'd2);
    request("R5", BASE + 32'h20, 4'b0001, 1'b0, 32'h20);
    request("R5", BASE + HALF - 1, 4'b0001, 1'b0, HALF - 1);
    request("R5", BASE + HALF, 4'b0100, 1'b0, '0);
    request("R5", BASE + 2*HALF - 1, 4'b0100, 1'b0, HALF - 1);
    request("R7", BASE + 2*HALF, 4'b0000, 1'b1, '0);
  endtask

  task automatic testBadCount();
    layout(3'd3);
    request("R6", BASE, 4'b0000, 1'b1, '0);
    request("R6", BASE + QTR, 4'b0000, 1'b1, '0);
    layout(3'd0);
    request("R6", BASE + 5, 4'b0000, 1'b1, '0);
    layout(3'd4);
    request("R6", BASE + 5, 4'b0001, 1'b0, 32'd5);
  endtask

  task automatic testDirectWrites();
    // quad layout active; collapse A2 onto A1's top
    writeTop(2'd1, BASE + QTR);
    request("R11", BASE + QTR, 4'b0100, 1'b0, '0);
    request("R11", BASE + 32'h0280_0000, 4'b0100, 1'b0, 32'h0180_0000);
    writeTop(2'd3, BASE + 32'h0500_0000);
    request("R10", BASE + 32'h0480_0000, 4'b1000, 1'b0, 32'h0180_0000);
    request("R10", BASE + 32'h0500_0000, 4'b0000, 1'b1, '0);
  endtask

  initial begin
    testReset();
    testWriteNoEnable();
    testQuad();
    testIdle();
    testPair();
    testBadCount();
    testDirectWrites();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule